// File: doc/BRIEF.md
# ADC Host Bus Interface

This block is the host-facing digital port of a sampling converter. A host writes an 8-bit configuration word and reads back 13-bit conversion results. The results are 12 magnitude bits plus a sign at bit 12, in two's complement. The conversion engine hands each new result to the block as a 13-bit word with a one-cycle valid strobe. The block keeps the latest result, optionally clamps negative results to zero, and presents it on the data pins.

The configuration word selects the acquisition time, the single-ended clamp, the host bus width, the sync mode and a 3-bit command. Each field is brought out as a decoded output for the rest of the device. With the narrow bus selected, only the low eight data pins are ever enabled. A result then takes two reads: the low byte first, then the upper five bits sign-extended to a full byte. With the wide bus selected, a single read presents all 13 bits.

The pad ring builds the tri-state pins from a separate output value and a per-pin output enable. The block drives the enables only while the host is reading.

Top module: `adc_host_if`

## Requirements
- R1: After reset the configuration is 0x10. The decoded outputs are then: acquisition select 0, clamp off, narrow bus, sync mode 1 and command 0. The stored result is zero, and the first narrow read returns its low byte.
- R2: A cycle with chip-select and write high and read low loads `data_i[7:0]` into the configuration; the new fields show on the outputs after that edge. The fields are: bits 1:0 acquisition select, bit 2 clamp enable, bit 3 bus width (1 = wide), bit 4 sync mode, bits 7:5 command.
- R3: No output enable is asserted unless chip-select and read are both high.
- R4: During a read with the wide bus selected, all 13 output enables are high and `data_o` equals the stored result.
- R5: During a read with the narrow bus selected, enables 7:0 are high and enables 12:8 are low. The first read after a pointer reset presents result bits 7:0 on `data_o[7:0]`.
- R6: In narrow mode the read that follows a low-byte read presents `{3 copies of bit 12, bits 12:8}` on `data_o[7:0]`. The read after that returns the low byte again.
- R7: A configuration write or an incoming result returns the byte pointer to the low byte.
- R8: A result with `res_valid_i` high is stored at that edge. It is stored as zero if the clamp is enabled and bit 12 of the result is 1; otherwise it is stored unchanged.
- R9: A read counts as one access for the whole time chip-select and read stay high, whatever its length. The pointer advances only when that access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| data_i | input | 8 | Configuration write data from the pins |
| data_o | output | 13 | Read data to the pins |
| data_oe_o | output | 13 | Per-pin output enable |
| res_valid_i | input | 1 | New conversion result strobe |
| res_data_i | input | 13 | Conversion result, two's complement |
| acq_sel_o | output | 2 | Acquisition time select |
| clamp_en_o | output | 1 | Single-ended clamp enable |
| bus_wide_o | output | 1 | Wide (13-bit) bus selected |
| sync_mode_o | output | 1 | Synchronous conversion mode |
| cmd_o | output | 3 | Command field |

## Verification
The result path is driven with positive values, negative values and values at the boundary of the magnitude range. Each is run under every combination of clamp enable and bus width. This separates a missing clamp from wrong sign extension, and a stuck byte pointer from a wrong pin enable. Directed sequences then interrupt a byte pair with a new result or a configuration write, and stretch a read over several cycles. These show whether the pointer resets and advances once per access rather than once per cycle.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int RES_W  = 13;
  localparam int CFG_W  = 8;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [2:0] cmd;
    logic       sync;
    logic       wide;
    logic       clamp;
    logic [1:0] acq;
  } cfg_t;

  localparam cfg_t CFG_RST = '{cmd: 3'b000, sync: 1'b1, wide: 1'b0, clamp: 1'b0, acq: 2'b00};
endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
  import adc_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= CFG_RST;
    else if (we_i) cfg_o <= cfg_t'(wdata_i);
  end
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             clamp_i,
  output logic [RES_W-1:0] res_o
);
  logic neg_clip;
  assign neg_clip = clamp_i & data_i[RES_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_o <= '0;
    else if (valid_i) res_o <= neg_clip ? '0 : data_i;
  end
endmodule

// File: rtl/adc_byte_seq.sv
module adc_byte_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic clr_i,
  output logic hi_o
);
  logic acc_q;
  logic acc_end;

  // one advance per access, taken when the strobe drops
  assign acc_end = acc_q & ~acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      hi_o  <= 1'b0;
    end else begin
      acc_q <= acc_i;
      if (clr_i)        hi_o <= 1'b0;
      else if (acc_end) hi_o <= ~hi_o;
    end
  end
endmodule

// File: rtl/adc_bus_drv.sv
module adc_bus_drv #(
  parameter int RES_W  = 13,
  parameter int BYTE_W = 8
) (
  input  logic             acc_i,
  input  logic             wide_i,
  input  logic             hi_i,
  input  logic [RES_W-1:0] res_i,
  output logic [RES_W-1:0] data_o,
  output logic [RES_W-1:0] oe_o
);
  localparam int HI_W  = RES_W - BYTE_W;
  localparam int EXT_W = BYTE_W - HI_W;

  logic [BYTE_W-1:0] hi_byte;
  logic [BYTE_W-1:0] nar_byte;

  assign hi_byte  = {{EXT_W{res_i[RES_W-1]}}, res_i[RES_W-1:BYTE_W]};
  assign nar_byte = hi_i ? hi_byte : res_i[BYTE_W-1:0];

  always_comb begin
    if (!acc_i)     data_o = '0;
    else if (wide_i) data_o = res_i;
    else             data_o = {{HI_W{1'b0}}, nar_byte};
  end

  for (genvar i = 0; i < RES_W; i++) begin : g_oe
    if (i < BYTE_W) begin : g_low
      assign oe_o[i] = acc_i;
    end else begin : g_up
      assign oe_o[i] = acc_i & wide_i;
    end
  end
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_pkg::*;
#(
  parameter int RES_W  = adc_host_pkg::RES_W,
  parameter int BYTE_W = adc_host_pkg::BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [RES_W-1:0] data_o,
  output logic [RES_W-1:0] data_oe_o,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_data_i,
  output logic [1:0]       acq_sel_o,
  output logic             clamp_en_o,
  output logic             bus_wide_o,
  output logic             sync_mode_o,
  output logic [2:0]       cmd_o
);
  cfg_t             cfg_q;
  logic [RES_W-1:0] res_q;
  logic             hi_q;
  logic             rd_acc;
  logic             cfg_we;

  assign rd_acc = cs_i & rd_i;
  assign cfg_we = cs_i & wr_i & ~rd_i;

  adc_cfg_reg i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we),
    .wdata_i(data_i),
    .cfg_o  (cfg_q)
  );

  adc_result_reg #(.RES_W(RES_W)) i_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(res_valid_i),
    .data_i (res_data_i),
    .clamp_i(cfg_q.clamp),
    .res_o  (res_q)
  );

  adc_byte_seq i_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .acc_i (rd_acc),
    .clr_i (cfg_we | res_valid_i),
    .hi_o  (hi_q)
  );

  adc_bus_drv #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_drv (
    .acc_i (rd_acc),
    .wide_i(cfg_q.wide),
    .hi_i  (hi_q),
    .res_i (res_q),
    .data_o(data_o),
    .oe_o  (data_oe_o)
  );

  assign acq_sel_o   = cfg_q.acq;
  assign clamp_en_o  = cfg_q.clamp;
  assign bus_wide_o  = cfg_q.wide;
  assign sync_mode_o = cfg_q.sync;
  assign cmd_o       = cfg_q.cmd;
endmodule

// File: rtl/adc_host_if_chk.sv
module adc_host_if_chk #(
  parameter int RES_W  = 13,
  parameter int BYTE_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic [7:0]       data_i,
  input logic [RES_W-1:0] data_o,
  input logic [RES_W-1:0] data_oe_o,
  input logic             res_valid_i,
  input logic [RES_W-1:0] res_data_i,
  input logic [1:0]       acq_sel_o,
  input logic             clamp_en_o,
  input logic             bus_wide_o,
  input logic             sync_mode_o,
  input logic [2:0]       cmd_o,
  input logic [RES_W-1:0] res_q,
  input logic             hi_q
);
  localparam int HI_W  = RES_W - BYTE_W;
  localparam int EXT_W = BYTE_W - HI_W;

  assert_no_drive_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> data_oe_o == '0);

  assert_wide_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && bus_wide_o) |-> (data_oe_o == '1 && data_o == res_q));

  assert_narrow_pins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && !bus_wide_o) |->
      (data_oe_o[RES_W-1:BYTE_W] == '0 && data_oe_o[BYTE_W-1:0] == '1));

  assert_narrow_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && !bus_wide_o && !hi_q) |-> data_o[BYTE_W-1:0] == res_q[BYTE_W-1:0]);

  assert_sign_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && !bus_wide_o && hi_q) |->
      data_o[BYTE_W-1:0] == {{EXT_W{res_q[RES_W-1]}}, res_q[RES_W-1:BYTE_W]});

  assert_cfg_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !rd_i) |=>
      {cmd_o, sync_mode_o, bus_wide_o, clamp_en_o, acq_sel_o} == $past(data_i));

  assert_ptr_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i || (cs_i && wr_i && !rd_i)) |=> !hi_q);

  assert_store_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !(clamp_en_o && res_data_i[RES_W-1])) |=> res_q == $past(res_data_i));

  assert_store_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && clamp_en_o && res_data_i[RES_W-1]) |=> res_q == '0);

  assert_ptr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && !res_valid_i && !wr_i) |=> $stable(hi_q));
endmodule

bind adc_host_if adc_host_if_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .data_i     (data_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .res_valid_i(res_valid_i),
  .res_data_i (res_data_i),
  .acq_sel_o  (acq_sel_o),
  .clamp_en_o (clamp_en_o),
  .bus_wide_o (bus_wide_o),
  .sync_mode_o(sync_mode_o),
  .cmd_o      (cmd_o),
  .res_q      (res_q),
  .hi_q       (hi_q)
);

// File: tb/test_adc_host_if.sv
module test_adc_host_if;
  localparam int RES_W = 13;
  localparam int NVEC  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]       data_i = '0;
  logic [RES_W-1:0] data_o, data_oe_o;
  logic             res_valid_i = 1'b0;
  logic [RES_W-1:0] res_data_i = '0;
  logic [1:0]       acq_sel_o;
  logic             clamp_en_o, bus_wide_o, sync_mode_o;
  logic [2:0]       cmd_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  adc_host_if i_adc_host_if (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .res_valid_i(res_valid_i), .res_data_i(res_data_i),
    .acq_sel_o(acq_sel_o), .clamp_en_o(clamp_en_o), .bus_wide_o(bus_wide_o),
    .sync_mode_o(sync_mode_o), .cmd_o(cmd_o)
  );

  // {clamp, wide, result}
  localparam logic [RES_W+1:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 13'h0ABC}, {1'b0, 1'b1, 13'h1F00},
    {1'b1, 1'b1, 13'h1F00}, {1'b1, 1'b1, 13'h0FFF},
    {1'b0, 1'b0, 13'h1234}, {1'b0, 1'b0, 13'h0765},
    {1'b1, 1'b0, 13'h1001}, {1'b1, 1'b0, 13'h00FE}
  };

  function automatic logic [RES_W-1:0] stored(input logic cl, input logic [RES_W-1:0] r);
    return (cl && r[12]) ? '0 : r;
  endfunction
  function automatic logic [7:0] hi_of(input logic [RES_W-1:0] r);
    return {{3{r[12]}}, r[12:8]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk_i); cs_i = 1; wr_i = 1; data_i = v;
    @(negedge clk_i); cs_i = 0; wr_i = 0; data_i = '0;
  endtask

  task automatic push_res(input logic [RES_W-1:0] v);
    @(negedge clk_i); res_valid_i = 1; res_data_i = v;
    @(negedge clk_i); res_valid_i = 0; res_data_i = '0;
  endtask

  task automatic read_bus(input int len, output logic [RES_W-1:0] d, output logic [RES_W-1:0] oe);
    @(negedge clk_i); cs_i = 1; rd_i = 1;
    #1 d = data_o; oe = data_oe_o;
    for (int k = 1; k < len; k++) @(negedge clk_i);
    #1 if (len > 1) begin
      check("R9 held read", {19'd0, data_o}, {19'd0, d});
    end
    @(negedge clk_i); cs_i = 0; rd_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [RES_W-1:0] d, oe, s;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    check("R1 cfg", {24'd0, cmd_o, sync_mode_o, bus_wide_o, clamp_en_o, acq_sel_o}, 32'h10);
    check("R3 idle oe", {19'd0, data_oe_o}, 32'h0);
    read_bus(1, d, oe);
    check("R1 result low", {19'd0, d}, 32'h0);
    check("R5 narrow oe", {19'd0, oe}, 32'h0FF);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic cl, wd;
      logic [RES_W-1:0] r;
      {cl, wd, r} = VEC[i];
      write_cfg({3'b000, 1'b0, wd, cl, 2'b00});
      push_res(r);
      s = stored(cl, r);
      read_bus(1, d, oe);
      if (wd) begin
        check("R4 wide oe", {19'd0, oe}, 32'h1FFF);
        check("R4/R8 wide data", {19'd0, d}, {19'd0, s});
      end else begin
        check("R5 narrow oe", {19'd0, oe}, 32'h0FF);
        check("R5/R8 low byte", {24'd0, d[7:0]}, {24'd0, s[7:0]});
        read_bus(1, d, oe);
        check("R6 high byte", {24'd0, d[7:0]}, {24'd0, hi_of(s)});
        read_bus(1, d, oe);
        check("R6 wrap to low", {24'd0, d[7:0]}, {24'd0, s[7:0]});
      end
    end

    // R2 field decode
    write_cfg(8'hAE);
    check("R2 acq", {30'd0, acq_sel_o}, 32'd2);
    check("R2 clamp", {31'd0, clamp_en_o}, 32'd1);
    check("R2 wide", {31'd0, bus_wide_o}, 32'd1);
    check("R2 sync", {31'd0, sync_mode_o}, 32'd0);
    check("R2 cmd", {29'd0, cmd_o}, 32'd5);

    // R3 no drive without chip-select, nor during write
    @(negedge clk_i); rd_i = 1;
    #1 check("R3 rd no cs", {19'd0, data_oe_o}, 32'h0);
    @(negedge clk_i); rd_i = 0; cs_i = 1; wr_i = 1; data_i = 8'hAE;
    #1 check("R3 during write", {19'd0, data_oe_o}, 32'h0);
    @(negedge clk_i); cs_i = 0; wr_i = 0;

    // R7 pointer cleared by new result and by config write
    write_cfg(8'h00);
    push_res(13'h0155);
    read_bus(1, d, oe);
    check("R7 first low", {24'd0, d[7:0]}, 32'h55);
    push_res(13'h0A3C);
    read_bus(1, d, oe);
    check("R7 low after new result", {24'd0, d[7:0]}, 32'h3C);
    read_bus(1, d, oe);
    check("R6 high positive", {24'd0, d[7:0]}, 32'h0A);
    read_bus(1, d, oe);
    write_cfg(8'h00);
    read_bus(1, d, oe);
    check("R7 low after cfg write", {24'd0, d[7:0]}, 32'h3C);

    // R9 long read strobe counts once
    push_res(13'h1ABC);
    read_bus(3, d, oe);
    check("R9 long read low", {24'd0, d[7:0]}, 32'hBC);
    read_bus(1, d, oe);
    check("R9 next is high", {24'd0, d[7:0]}, 32'hFA);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule